// File: doc/BRIEF.md
# Wake-up Event Flag Controller

This block belongs to the power management logic of a small microcontroller. It receives single-cycle strobes from five wake-up sources: divider 0 overflow, timer 0 underflow, a pin-change detector, divider 1 overflow and timer 1 underflow. Each strobe is recorded in an 8-bit event flag register. When the source is also enabled for hold release, the strobe is recorded in an 8-bit release-cause register as well. The two registers put some sources at different bit positions, and the positions that are not used always read as zero.

Any set bit in the release-cause register ends the low-power hold state and blocks entry into it. A hold request made while a cause bit is pending is dropped. Software can clear event flags with a masked clear command, and taking a source's interrupt also clears its flag. A cause bit is not cleared directly: it drops only once both its event flag and its hold-enable bit are zero. The cause register can also be read through a 4-bit port with separate selects for the low and high nibbles.

Top module: `wake_evt_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, both registers, the enable mask, `hold_active`, `wake` and `cause_nib` are zero after that edge.
- R2: A strobe on `ev_strobe[s]` sets the event flag bit on the next edge. The source order is s=0 divider 0, 1 timer 0, 2 pin change, 3 divider 1, 4 timer 1, and the flag positions are 0, 1, 2, 4 and 7. Event flag bits 3, 5 and 6 always read 0.
- R3: When `clr_cmd` is high, each event flag bit whose `clr_mask` bit (same position as in `evt_flags`) is 1 is cleared on the next edge. A strobe in the same cycle wins, and mask bits at reserved positions have no effect.
- R4: `int_ack[s]` clears the event flag of source s on the next edge. A strobe from the same source in the same cycle wins.
- R5: A strobe on source s while enable bit s is 1 sets the cause bit on the next edge, at positions 0, 1, 2, 4 and 5 for s=0..4. A strobe while enable bit s is 0 leaves the cause bit unchanged. Cause bits 3, 6 and 7 always read 0.
- R6: A set cause bit stays set while its event flag or its enable bit is 1. It clears on the same edge at which the last of the two becomes 0.
- R7: When `hold_active` is 0 and no cause bit is set, `hold_req` makes `hold_active` 1 on the next edge. When any cause bit is set, `hold_req` is ignored.
- R8: While `hold_active` is 1 and any cause bit is set, the next edge clears `hold_active` and raises `wake` for exactly one cycle.
- R9: `cause_nib` shows cause bits 3:0 when `rd_cause_lo` is 1, otherwise bits 7:4 when `rd_cause_hi` is 1, otherwise 0.
- R10: When `en_wr` is 1, the next edge loads `en_wdata` into the hold-enable mask, using the source order of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_strobe | input | 5 | One-cycle event strobes, in source order |
| en_wr | input | 1 | Load the hold-enable mask |
| en_wdata | input | 5 | New hold-enable mask, in source order |
| clr_cmd | input | 1 | Masked event flag clear |
| clr_mask | input | 8 | Clear mask, in event flag bit positions |
| int_ack | input | 5 | Interrupt taken, per source |
| hold_req | input | 1 | Request to enter hold |
| rd_cause_lo | input | 1 | Select the low cause nibble |
| rd_cause_hi | input | 1 | Select the high cause nibble |
| evt_flags | output | 8 | Event flag register |
| cause_flags | output | 8 | Hold release cause register |
| cause_nib | output | 4 | Selected cause nibble |
| hold_active | output | 1 | Hold state is active |
| wake | output | 1 | One-cycle pulse on leaving hold |

## Verification
The stimulus sends strobes from enabled and disabled sources, so the two registers must diverge, and it uses timer 1, the one source that sits at a different bit in each register. Clears arrive both through the masked command and through interrupt acknowledge, alone and together with a strobe, which shows whether a set beats a clear. The cause-bit release is driven in both orders: flag cleared first and enable cleared second, and the reverse, so it shows whether the bit waits for the last of the two. Hold requests are made with a cause bit pending and without one, and a wake is triggered from inside hold, which shows whether entry is gated, whether exit occurs, and whether the wake pulse lasts exactly one cycle.

// File: rtl/wake_evt_pkg.sv
// Shared constants for the wake-up event flag controller.
// Holds the source count, the register width and the bit position that
// each source takes in the event flag and release-cause registers.
package wake_evt_pkg;
    localparam int NSRC  = 5;
    localparam int REG_W = 8;

    // Bit of the event flag register that each source sets.
    function automatic int evf_pos(input int s);
        case (s)
            0:       return 0;
            1:       return 1;
            2:       return 2;
            3:       return 4;
            default: return 7;
        endcase
    endfunction

    // Bit of the release-cause register that each source sets.
    function automatic int cause_pos(input int s);
        case (s)
            0:       return 0;
            1:       return 1;
            2:       return 2;
            3:       return 4;
            default: return 5;
        endcase
    endfunction

    // Mask of the event flag bits that are in use.
    function automatic logic [REG_W-1:0] evf_used();
        logic [REG_W-1:0] m;
        m = '0;
        for (int s = 0; s < NSRC; s++) m[evf_pos(s)] = 1'b1;
        return m;
    endfunction

    // Mask of the release-cause bits that are in use.
    function automatic logic [REG_W-1:0] cause_used();
        logic [REG_W-1:0] m;
        m = '0;
        for (int s = 0; s < NSRC; s++) m[cause_pos(s)] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/wake_evt_flags.sv
// Event flag register. Each source has one flag. A strobe sets it; a
// masked clear command or that source's interrupt acknowledge clears it.
// A set wins over a clear in the same cycle. The flag's next value is
// also provided so the cause logic can release on the same edge.
// Assumes strobes are one-cycle and synchronous to clk.
module wake_evt_flags
    import wake_evt_pkg::*;
#(
    parameter int N = NSRC,
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] strobe,
    input  logic         clr_cmd,
    input  logic [W-1:0] clr_mask,
    input  logic [N-1:0] ack,
    output logic [N-1:0] flag_q,
    output logic [N-1:0] flag_nxt,
    output logic [W-1:0] flag_reg
);
    localparam logic [W-1:0] USED = evf_used();

    logic [N-1:0] clr_src;

    for (genvar g = 0; g < N; g++) begin : g_src
        localparam int P = evf_pos(g);
        // Per-source clear from the masked command, read at this source's bit.
        assign clr_src[g]  = clr_cmd & clr_mask[P];
        // Next flag value: a set beats either kind of clear.
        assign flag_nxt[g] = strobe[g] | (flag_q[g] & ~clr_src[g] & ~ack[g]);

        // R2: a strobe is always recorded on the next edge.
        a_r2_strobe_sets: assert property (@(posedge clk) disable iff (!rst_n)
            strobe[g] |=> flag_reg[P]);
        // R4: an acknowledge without a strobe drops the flag.
        a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (ack[g] && !strobe[g]) |=> !flag_reg[P]);
    end

    // Flag storage with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_nxt;
    end

    // Place each source's flag at its register position.
    always_comb begin
        flag_reg = '0;
        for (int s = 0; s < N; s++) flag_reg[evf_pos(s)] = flag_q[s];
    end

    // R2: reserved positions stay zero.
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_reg & ~USED) == '0);
    // R3: clear mask bits at reserved positions leave the register clean.
    a_r3_reserved_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_cmd && ((clr_mask & ~USED) != '0)) |=> ((flag_reg & ~USED) == '0));
endmodule

// File: rtl/wake_en_mask.sv
// Hold-enable mask, one bit per source, loaded by a write strobe.
// Also provides the next value so the cause logic can release on the
// same edge as an enable clear.
module wake_en_mask
    import wake_evt_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] en_q,
    output logic [N-1:0] en_nxt
);
    // Next mask value: load on write, otherwise hold.
    assign en_nxt = wr ? wdata : en_q;

    // Mask storage with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_nxt;
    end

    // R10: a write lands on the next edge.
    a_r10_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (en_q == $past(wdata)));
endmodule

// File: rtl/wake_cause_reg.sv
// Hold release-cause register. A strobe from an enabled source sets its
// bit. A set bit is kept until both the source's event flag and its
// enable bit are zero, and it releases on the edge where that becomes
// true. Assumes the next values of the flags and the mask come from
// their own registers.
module wake_cause_reg
    import wake_evt_pkg::*;
#(
    parameter int N = NSRC,
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] strobe,
    input  logic [N-1:0] en_q,
    input  logic [N-1:0] en_nxt,
    input  logic [N-1:0] flag_nxt,
    output logic [N-1:0] cause_q,
    output logic [W-1:0] cause_reg,
    output logic         cause_any
);
    localparam logic [W-1:0] USED = cause_used();

    logic [N-1:0] cause_nxt;

    // Next cause: set on an enabled strobe, otherwise kept while flag or enable remain.
    assign cause_nxt = (strobe & en_q) | (cause_q & (flag_nxt | en_nxt));

    // Cause storage with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cause_q <= '0;
        else        cause_q <= cause_nxt;
    end

    // Place each source's cause at its register position.
    always_comb begin
        cause_reg = '0;
        for (int s = 0; s < N; s++) cause_reg[cause_pos(s)] = cause_q[s];
    end

    // Summary used to gate hold.
    assign cause_any = |cause_q;

    for (genvar g = 0; g < N; g++) begin : g_chk
        // R5: an enabled strobe is recorded on the next edge.
        a_r5_enabled_sets: assert property (@(posedge clk) disable iff (!rst_n)
            (strobe[g] && en_q[g]) |=> cause_reg[cause_pos(g)]);
        // R5: a disabled strobe cannot raise a clear cause bit.
        a_r5_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            (!strobe[g] || !en_q[g]) && !cause_q[g] |=> !cause_q[g]);
    end

    // R5: reserved positions stay zero.
    a_r5_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_reg & ~USED) == '0);
endmodule

// File: rtl/wake_hold_fsm.sv
// Hold state machine. A request enters hold only while no cause bit is
// pending. A pending cause ends hold on the next edge, and a registered
// wake pulse is raised for that one cycle.
module wake_hold_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_req,
    input  logic cause_any,
    output logic hold_active,
    output logic wake
);
    typedef enum logic {HS_RUN = 1'b0, HS_HOLD = 1'b1} hold_st_t;

    hold_st_t st_q, st_d;

    // Next state: gated entry, exit on any cause.
    always_comb begin
        st_d = st_q;
        case (st_q)
            HS_RUN:  if (hold_req && !cause_any) st_d = HS_HOLD;
            HS_HOLD: if (cause_any)              st_d = HS_RUN;
            default: st_d = HS_RUN;
        endcase
    end

    // State and wake pulse registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= HS_RUN;
            wake <= 1'b0;
        end else begin
            st_q <= st_d;
            wake <= (st_q == HS_HOLD) && cause_any;
        end
    end

    assign hold_active = (st_q == HS_HOLD);

    // R7: a request with a pending cause is ignored.
    a_r7_gated_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_active && cause_any) |=> !hold_active);
    // R7: a clean request is accepted.
    a_r7_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_active && !cause_any && hold_req) |=> hold_active);
    // R8: a pending cause ends hold and raises wake.
    a_r8_exit_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_active && cause_any) |=> (!hold_active && wake));
    // R8: wake lasts one cycle.
    a_r8_wake_single: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> !wake);
endmodule

// File: rtl/wake_evt_ctrl.sv
// Top of the wake-up event flag controller. Connects the event flag
// register, the hold-enable mask, the release-cause register and the
// hold state machine, and provides the nibble read of the cause register.
// Assumes single-cycle strobes and one clock domain.
module wake_evt_ctrl
    import wake_evt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NSRC-1:0]      ev_strobe,
    input  logic                 en_wr,
    input  logic [NSRC-1:0]      en_wdata,
    input  logic                 clr_cmd,
    input  logic [REG_W-1:0]     clr_mask,
    input  logic [NSRC-1:0]      int_ack,
    input  logic                 hold_req,
    input  logic                 rd_cause_lo,
    input  logic                 rd_cause_hi,
    output logic [REG_W-1:0]     evt_flags,
    output logic [REG_W-1:0]     cause_flags,
    output logic [REG_W/2-1:0]   cause_nib,
    output logic                 hold_active,
    output logic                 wake
);
    localparam int NIB = REG_W / 2;

    logic [NSRC-1:0] flag_q, flag_nxt, en_q, en_nxt, cause_q;
    logic            cause_any;

    wake_evt_flags #(.N(NSRC), .W(REG_W)) u_flags (
        .clk(clk), .rst_n(rst_n), .strobe(ev_strobe), .clr_cmd(clr_cmd),
        .clr_mask(clr_mask), .ack(int_ack), .flag_q(flag_q),
        .flag_nxt(flag_nxt), .flag_reg(evt_flags)
    );

    wake_en_mask #(.N(NSRC)) u_en (
        .clk(clk), .rst_n(rst_n), .wr(en_wr), .wdata(en_wdata),
        .en_q(en_q), .en_nxt(en_nxt)
    );

    wake_cause_reg #(.N(NSRC), .W(REG_W)) u_cause (
        .clk(clk), .rst_n(rst_n), .strobe(ev_strobe), .en_q(en_q),
        .en_nxt(en_nxt), .flag_nxt(flag_nxt), .cause_q(cause_q),
        .cause_reg(cause_flags), .cause_any(cause_any)
    );

    wake_hold_fsm u_hold (
        .clk(clk), .rst_n(rst_n), .hold_req(hold_req), .cause_any(cause_any),
        .hold_active(hold_active), .wake(wake)
    );

    // Nibble read: low select has priority, no select reads zero.
    always_comb begin
        if (rd_cause_lo)      cause_nib = cause_flags[NIB-1:0];
        else if (rd_cause_hi) cause_nib = cause_flags[REG_W-1:NIB];
        else                  cause_nib = '0;
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_link
        // R6: a set cause bit always has its flag or its enable behind it.
        a_r6_cause_backed: assert property (@(posedge clk) disable iff (!rst_n)
            cause_q[g] |-> (flag_q[g] || en_q[g]));
        // R6: while flag or enable stays set, the cause bit stays set.
        a_r6_cause_kept: assert property (@(posedge clk) disable iff (!rst_n)
            (cause_q[g] && (flag_nxt[g] || en_nxt[g])) |=> cause_q[g]);
    end
endmodule

// File: tb/sim_wake_evt_ctrl.sv
`timescale 1ns/100ps
module sim_wake_evt_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] ev_strobe = '0, en_wdata = '0, int_ack = '0;
    logic       en_wr = 1'b0, clr_cmd = 1'b0, hold_req = 1'b0;
    logic       rd_cause_lo = 1'b0, rd_cause_hi = 1'b0;
    logic [7:0] clr_mask = '0;
    logic [7:0] evt_flags, cause_flags;
    logic [3:0] cause_nib;
    logic       hold_active, wake;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    wake_evt_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .ev_strobe(ev_strobe), .en_wr(en_wr),
        .en_wdata(en_wdata), .clr_cmd(clr_cmd), .clr_mask(clr_mask),
        .int_ack(int_ack), .hold_req(hold_req), .rd_cause_lo(rd_cause_lo),
        .rd_cause_hi(rd_cause_hi), .evt_flags(evt_flags),
        .cause_flags(cause_flags), .cause_nib(cause_nib),
        .hold_active(hold_active), .wake(wake)
    );

    // Reference model state, per source in order div0, tmr0, pin, div1, tmr1.
    int EP[5] = '{0, 1, 2, 4, 7};
    int CP[5] = '{0, 1, 2, 4, 5};
    logic [4:0] m_flag = '0, m_en = '0, m_cause = '0;
    logic       m_hold = 1'b0;

    typedef struct {
        string      req;
        logic [7:0] evf;
        logic [7:0] cause;
        logic [3:0] nib;
        logic       hold;
        logic       wake;
    } exp_t;
    exp_t sb[$];

    function automatic logic [7:0] place(input logic [4:0] v, input bit cause);
        logic [7:0] r = '0;
        for (int s = 0; s < 5; s++) r[cause ? CP[s] : EP[s]] = v[s];
        return r;
    endfunction

    // Driver: apply one cycle of stimulus and push the expected result.
    task automatic step(input string req, input logic [4:0] stb,
                        input logic ew, input logic [4:0] ed,
                        input logic cc, input logic [7:0] cm,
                        input logic [4:0] ak, input logic hr,
                        input logic lo, input logic hi);
        exp_t e;
        logic [4:0] f_d, en_d, c_d;
        logic [7:0] cv;
        logic       any;
        @(negedge clk);
        ev_strobe = stb; en_wr = ew; en_wdata = ed; clr_cmd = cc;
        clr_mask = cm; int_ack = ak; hold_req = hr;
        rd_cause_lo = lo; rd_cause_hi = hi;
        any = |m_cause;
        for (int s = 0; s < 5; s++)
            f_d[s] = stb[s] | (m_flag[s] & ~(cc & cm[EP[s]]) & ~ak[s]);
        en_d = ew ? ed : m_en;
        c_d  = (stb & m_en) | (m_cause & (f_d | en_d));
        e.wake = m_hold & any;
        e.hold = m_hold ? ~any : (hr & ~any);
        m_flag = f_d; m_en = en_d; m_cause = c_d; m_hold = e.hold;
        cv = place(c_d, 1'b1);
        e.req = req; e.evf = place(f_d, 1'b0); e.cause = cv;
        e.nib = lo ? cv[3:0] : (hi ? cv[7:4] : 4'h0);
        sb.push_back(e);
    endtask

    task automatic idle(input string req);
        step(req, 5'b0, 1'b0, 5'b0, 1'b0, 8'h00, 5'b0, 1'b0, 1'b0, 1'b0);
    endtask

    // Monitor: pop and compare one item after each edge.
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_chk++;
            if (evt_flags !== e.evf || cause_flags !== e.cause || cause_nib !== e.nib ||
                hold_active !== e.hold || wake !== e.wake) begin
                n_fail++;
                $display("FAIL %s: got evf=%h cause=%h nib=%h hold=%b wake=%b, exp evf=%h cause=%h nib=%h hold=%b wake=%b",
                         e.req, evt_flags, cause_flags, cause_nib, hold_active, wake,
                         e.evf, e.cause, e.nib, e.hold, e.wake);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_chk++;  // R1 reset state
        if (evt_flags !== 8'h00 || cause_flags !== 8'h00 || cause_nib !== 4'h0 ||
            hold_active !== 1'b0 || wake !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: got evf=%h cause=%h nib=%h hold=%b wake=%b, exp all zero",
                     evt_flags, cause_flags, cause_nib, hold_active, wake);
        end
        rst_n = 1'b1;
        // R10 enable div0, pin, tmr1
        step("R10", 5'b0, 1'b1, 5'b10101, 1'b0, 8'h00, 5'b0, 1'b0, 1'b0, 1'b0);
        // R2 disabled tmr0 strobe: flag only
        step("R2", 5'b00010, 1'b0, 5'b0, 1'b0, 8'h00, 5'b0, 1'b0, 1'b0, 1'b0);
        // R5 enabled tmr1: flag bit 7, cause bit 5; R9 high nibble
        step("R5", 5'b10000, 1'b0, 5'b0, 1'b0, 8'h00, 5'b0, 1'b0, 1'b0, 1'b1);
        // R7 hold request with cause pending is ignored
        step("R7", 5'b0, 1'b0, 5'b0, 1'b0, 8'h00, 5'b0, 1'b1, 1'b0, 1'b1);
        // R4 ack tmr1: flag clears, cause kept (R6) since enabled; R9 low nibble
        step("R4", 5'b0, 1'b0, 5'b0, 1'b0, 8'h00, 5'b10000, 1'b0, 1'b1, 1'b0);
        // R6 clear tmr1 enable: cause releases on this edge
        step("R6", 5'b0, 1'b1, 5'b00101, 1'b0, 8'h00, 5'b0, 1'b0, 1'b0, 1'b1);
        // R3 masked clear of tmr0 with reserved mask bits also set
        step("R3", 5'b0, 1'b0, 5'b0, 1'b1, 8'h6A, 5'b0, 1'b0, 1'b0, 1'b0);
        // R7 clean hold request accepted
        step("R7", 5'b0, 1'b0, 5'b0, 1'b0, 8'h00, 5'b0, 1'b1, 1'b0, 1'b0);
        idle("R7");
        // R5 disabled div1 strobe in hold: no cause, stays in hold
        step("R5", 5'b01000, 1'b0, 5'b0, 1'b0, 8'h00, 5'b0, 1'b0, 1'b0, 1'b0);
        // R5 enabled div0 strobe in hold sets cause bit 0
        step("R5", 5'b00001, 1'b0, 5'b0, 1'b0, 8'h00, 5'b0, 1'b0, 1'b1, 1'b0);
        idle("R8");   // hold exits, wake high
        idle("R8");   // wake back low
        // R3 strobe and clear of pin change in same cycle: set wins
        step("R3", 5'b00100, 1'b0, 5'b0, 1'b1, 8'h04, 5'b0, 1'b0, 1'b0, 1'b0);
        // R6 clear all flags; div0 and pin causes kept by their enables
        step("R6", 5'b0, 1'b0, 5'b0, 1'b1, 8'hFF, 5'b0, 1'b0, 1'b1, 1'b0);
        // R6 disable all: causes release
        step("R6", 5'b0, 1'b1, 5'b00000, 1'b0, 8'h00, 5'b0, 1'b0, 1'b1, 1'b0);
        // R4 strobe and ack on timer 0 together: set wins
        step("R4", 5'b00010, 1'b0, 5'b0, 1'b0, 8'h00, 5'b00010, 1'b0, 1'b0, 1'b0);
        // R6 order reversed: enable div1, strobe, drop enable, then clear flag
        step("R10", 5'b0, 1'b1, 5'b01000, 1'b0, 8'h00, 5'b0, 1'b0, 1'b0, 1'b0);
        step("R5", 5'b01000, 1'b0, 5'b0, 1'b0, 8'h00, 5'b0, 1'b0, 1'b0, 1'b1);
        step("R6", 5'b0, 1'b1, 5'b00000, 1'b0, 8'h00, 5'b0, 1'b0, 1'b0, 1'b1);
        step("R6", 5'b0, 1'b0, 5'b0, 1'b0, 8'h00, 5'b01000, 1'b0, 1'b0, 1'b1);
        // R7 hold again, then reset during hold
        step("R7", 5'b0, 1'b0, 5'b0, 1'b0, 8'h00, 5'b0, 1'b1, 1'b0, 1'b0);
        idle("R7");
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        n_chk++;  // R1 reset from a busy state
        if (evt_flags !== 8'h00 || cause_flags !== 8'h00 || hold_active !== 1'b0 || wake !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: got evf=%h cause=%h hold=%b wake=%b, exp all zero",
                     evt_flags, cause_flags, hold_active, wake);
        end
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout, exp completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule